// File: doc/BRIEF.md
# Three-Level Space-Vector Triangle Locator and Dwell Timer

This block takes one sample of a rotating voltage reference, given as signed fixed-point alpha and beta components, together with the DC-link voltage and the switching period expressed in timer counts. It works out which of the six 60° sectors of the three-level hexagon holds the reference. It then finds which of the four triangles inside that sector holds the reference, and computes how many timer counts each of the three triangle corners must be applied for. A downstream sequencer turns these three counts into a switching pattern.

Inside, the reference is expressed in oblique coordinates along the two edges of its sector. This uses only additions and products with constants, and the sector choice is made from the signs of three linear combinations of alpha and beta. The two normalized components are turned into timer counts by two bit-serial dividers that run in parallel. For that reason every result takes the same fixed number of cycles. The three counts always add up to the switching period exactly.

A sample is handed over with a valid/ready pair. The result is held on the outputs until the consumer acknowledges it. Only after that does the block take the next sample.

Top module: `svp_locator`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` is 0, `smp_ready` is 1, and `sector`, `subsector`, `dwell0`, `dwell1` and `dwell2` are all 0 until the first result.
- R2: A sample is taken on a rising edge where `smp_valid` and `smp_ready` are both 1. From the next edge on, `smp_ready` is 0 until the result has been acknowledged. `smp_valid` pulses in that window are ignored and do not alter the pending result.
- R3: `res_valid` rises exactly LAT = NU + TW + 2 rising edges after the accepting edge, where NU = W + F + 2. With the defaults W=16, F=15, TW=16 this gives 51.
- R4: While `res_valid` is 1 and `res_ack` is 0, every result output holds its value. A `res_ack` of 1 while `res_valid` is 1 clears `res_valid` on the next edge, and `smp_ready` returns to 1 on that same edge.
- R5: With K = round(√3·2^F), tx = 3·2^F·alpha and ty = K·beta, let A = 2·ty, B = tx − ty and C = tx + ty. The sector, coded as the binary value 1 to 6, is the first match of this ordered list: 1 if B>0 and A≥0; 2 if C>0 and B≤0; 3 if A>0 and C≤0; 4 if B<0 and A≤0; 5 if C<0 and B≥0; 6 if A<0 and C≥0. If none matches (zero reference), the sector is 1.
- R6: The rotated components (N1, N2) are (B,A), (C,−B), (A,−C), (−B,−A), (−C,B) and (−A,C) for sectors 1 to 6. For the zero reference they are (0,0). With D = vdc·2^F, N1/D and N2/D equal twice the normalized components m1 and m2.
- R7: The sub-sector, coded as the binary value 1 to 4, is chosen as follows. If N1≥D and N2≥D, it is 3 when N1≥N2 and 4 otherwise. Otherwise it is 3 if N1≥D, and 4 if N2≥D. Otherwise it is 1 if N1+N2<D, and 2 if not.
- R8: The quotients are q1 = min(floor(N1·ts/D), 2·ts) and q2 = min(floor(N2·ts/D), 2·ts).
- R9: Before saturation, the raw dwells (e0, e2) are (q1, q2) in sub-sector 1, (ts−q2, ts−q1) in sub-sector 2, (q1−ts, q2) in sub-sector 3 and (q1, q2−ts) in sub-sector 4.
- R10: `dwell0` and `dwell2` are e0 and e2 clamped to the range 0 to ts. If the two clamped values together exceed ts, `dwell2` becomes ts − `dwell0`. `dwell1` = ts − `dwell0` − `dwell2`, so the three counts always add up to ts.
- R11: A zero reference gives sector 1, sub-sector 1, `dwell0` = `dwell2` = 0 and `dwell1` = ts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Block idle and no result pending |
| v_alpha | input | W | Signed alpha component of the reference |
| v_beta | input | W | Signed beta component of the reference |
| vdc | input | VW | DC-link voltage, same scale as the reference |
| ts | input | TW | Switching period in timer counts |
| res_valid | output | 1 | Result available |
| res_ack | input | 1 | Consumer takes the result |
| sector | output | 3 | Sector 1 to 6 |
| subsector | output | 3 | Triangle 1 to 4 within the sector |
| dwell0 | output | TW | Count for the corner along the sector's first edge |
| dwell1 | output | TW | Count for the remaining corner |
| dwell2 | output | TW | Count for the corner along the sector's second edge |

## Verification
A wrong sector choice or a wrong rotated component shows up in the very first result. It appears as a wrong sector or sub-sector code, or as dwell counts that differ from the arithmetic of R5 to R10. A divider that loses or gains an iteration appears at once in two ways: `res_valid` rises at the wrong edge, and the quotients come out scaled by a power of two. The sweep walks a grid of references over all six sectors and two DC-link/period settings, so it reaches every one of the 24 triangles. A corrupted capture register or hold logic is exposed within one result: either a result changes while it waits for `res_ack`, or a sample offered while busy leaks into it.

// File: rtl/svp_locator_pkg.sv
package svp_locator_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } svp_state_e;

  localparam int SEC_W = 3;
  localparam int SUB_W = 3;
  localparam int N_CH  = 2;
endpackage

// File: rtl/svp_sector_sel.sv
module svp_sector_sel #(
  parameter int W  = 16,
  parameter int F  = 15,
  parameter int NW = W + F + 3
) (
  input  logic signed [W-1:0]  v_alpha,
  input  logic signed [W-1:0]  v_beta,
  output logic [2:0]           sector,
  output logic [NW-2:0]        n1,
  output logic [NW-2:0]        n2
);
  localparam int NU = NW - 1;
  localparam longint ROOT3_Q = longint'(1.7320508075688772 * (2.0 ** F));
  localparam logic signed [NW-1:0] KX = NW'(longint'(3) << F);
  localparam logic signed [NW-1:0] KY = NW'(ROOT3_Q);

  logic signed [NW-1:0] ax, by, tx, ty, pa, pb, pc;

  assign ax = NW'(v_alpha);
  assign by = NW'(v_beta);
  assign tx = ax * KX;
  assign ty = by * KY;
  assign pa = ty + ty;
  assign pb = tx - ty;
  assign pc = tx + ty;

  // Half-open 60-degree wedges decided from the signs of three projections
  always_comb begin
    sector = 3'd1;
    n1     = '0;
    n2     = '0;
    if (pb > 0 && pa >= 0) begin
      sector = 3'd1; n1 = NU'(pb);  n2 = NU'(pa);
    end else if (pc > 0 && pb <= 0) begin
      sector = 3'd2; n1 = NU'(pc);  n2 = NU'(-pb);
    end else if (pa > 0 && pc <= 0) begin
      sector = 3'd3; n1 = NU'(pa);  n2 = NU'(-pc);
    end else if (pb < 0 && pa <= 0) begin
      sector = 3'd4; n1 = NU'(-pb); n2 = NU'(-pa);
    end else if (pc < 0 && pb >= 0) begin
      sector = 3'd5; n1 = NU'(-pc); n2 = NU'(pb);
    end else if (pa < 0 && pc >= 0) begin
      sector = 3'd6; n1 = NU'(-pa); n2 = NU'(pc);
    end
  end
endmodule

// File: rtl/svp_divider.sv
module svp_divider #(
  parameter int PW = 49,
  parameter int DW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [PW-1:0] quotient,
  output logic          done
);
  localparam int CNTW = $clog2(PW + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(PW);

  logic [DW:0]     rem_q, rem_d, rem_sh;
  logic [PW-1:0]   quo_q, quo_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            run_q, run_d;
  logic            step_en, fits;

  assign rem_sh  = {rem_q[DW-1:0], quo_q[PW-1]};
  assign fits    = rem_sh >= {1'b0, divisor};
  assign step_en = run_q && (cnt_q != LAST);

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      rem_d = '0;
      quo_d = dividend;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (step_en) begin
      rem_d = fits ? (rem_sh - {1'b0, divisor}) : rem_sh;
      quo_d = {quo_q[PW-2:0], fits};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start || step_en) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign quotient = quo_q;
  assign done     = run_q && (cnt_q == LAST);
endmodule

// File: rtl/svp_dwell_calc.sv
module svp_dwell_calc #(
  parameter int NU = 33,
  parameter int DW = 31,
  parameter int PW = 49,
  parameter int TW = 16
) (
  input  logic [NU-1:0] n1,
  input  logic [NU-1:0] n2,
  input  logic [DW-1:0] dvs,
  input  logic [PW-1:0] q1,
  input  logic [PW-1:0] q2,
  input  logic [TW-1:0] ts,
  output logic [2:0]    sub,
  output logic [TW-1:0] t0,
  output logic [TW-1:0] t1,
  output logic [TW-1:0] t2
);
  localparam int CW = NU + 1;
  localparam int EW = TW + 3;

  logic [CW-1:0] n1e, n2e, de, nsum;
  logic          ge1, ge2;
  logic [TW:0]   ts2, qc1, qc2;
  logic signed [EW-1:0] tse, qe1, qe2, e0, e2;
  logic [TW-1:0] s0, s2, s2f;

  assign n1e  = CW'(n1);
  assign n2e  = CW'(n2);
  assign de   = CW'(dvs);
  assign nsum = n1e + n2e;
  assign ge1  = n1e >= de;
  assign ge2  = n2e >= de;

  // Triangle choice inside the sector
  always_comb begin
    if (ge1 && ge2)      sub = (n1e >= n2e) ? 3'd3 : 3'd4;
    else if (ge1)        sub = 3'd3;
    else if (ge2)        sub = 3'd4;
    else if (nsum < de)  sub = 3'd1;
    else                 sub = 3'd2;
  end

  assign ts2 = {ts, 1'b0};
  assign qc1 = (q1 > PW'(ts2)) ? ts2 : q1[TW:0];
  assign qc2 = (q2 > PW'(ts2)) ? ts2 : q2[TW:0];
  assign tse = $signed({3'b000, ts});
  assign qe1 = $signed({2'b00, qc1});
  assign qe2 = $signed({2'b00, qc2});

  always_comb begin
    case (sub)
      3'd2:    begin e0 = tse - qe2; e2 = tse - qe1; end
      3'd3:    begin e0 = qe1 - tse; e2 = qe2;       end
      3'd4:    begin e0 = qe1;       e2 = qe2 - tse; end
      default: begin e0 = qe1;       e2 = qe2;       end
    endcase
  end

  function automatic logic [TW-1:0] clamp_ts(input logic signed [EW-1:0] v,
                                             input logic signed [EW-1:0] lim);
    if (v < 0)        return '0;
    else if (v > lim) return lim[TW-1:0];
    else              return v[TW-1:0];
  endfunction

  assign s0  = clamp_ts(e0, tse);
  assign s2  = clamp_ts(e2, tse);
  assign s2f = (({1'b0, s0} + {1'b0, s2}) > {1'b0, ts}) ? (ts - s0) : s2;
  assign t0  = s0;
  assign t2  = s2f;
  assign t1  = ts - s0 - s2f;
endmodule

// File: rtl/svp_locator.sv
module svp_locator #(
  parameter int W  = 16,
  parameter int VW = 16,
  parameter int TW = 16,
  parameter int F  = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic signed [W-1:0]  v_alpha,
  input  logic signed [W-1:0]  v_beta,
  input  logic [VW-1:0]        vdc,
  input  logic [TW-1:0]        ts,
  output logic                 res_valid,
  input  logic                 res_ack,
  output logic [2:0]           sector,
  output logic [2:0]           subsector,
  output logic [TW-1:0]        dwell0,
  output logic [TW-1:0]        dwell1,
  output logic [TW-1:0]        dwell2
);
  import svp_locator_pkg::*;

  localparam int NW  = W + F + 3;
  localparam int NU  = NW - 1;
  localparam int PW  = NU + TW;
  localparam int DW  = VW + F;
  localparam int LAT = PW + 2;

  // Reset: asserted at once, released through two flops
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // Sector and rotated components from the live inputs
  logic [2:0]    sec_c;
  logic [NU-1:0] n1_c, n2_c;
  svp_sector_sel #(.W(W), .F(F), .NW(NW)) sel_i (
    .v_alpha (v_alpha),
    .v_beta  (v_beta),
    .sector  (sec_c),
    .n1      (n1_c),
    .n2      (n2_c)
  );

  // Captured operands
  svp_state_e    state_q, state_d;
  logic [2:0]    sec_q;
  logic [NU-1:0] n_q [N_CH];
  logic [TW-1:0] ts_q;
  logic [DW-1:0] dvs_q;
  logic          cap_en, out_en, start_div, all_done;
  logic          rv_q, rv_d;

  assign smp_ready = (state_q == ST_IDLE) && !rv_q;
  assign cap_en    = smp_valid && smp_ready;
  assign start_div = (state_q == ST_START);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sec_q   <= '0;
      n_q[0]  <= '0;
      n_q[1]  <= '0;
      ts_q    <= '0;
      dvs_q   <= '0;
    end else if (cap_en) begin
      sec_q   <= sec_c;
      n_q[0]  <= n1_c;
      n_q[1]  <= n2_c;
      ts_q    <= ts;
      dvs_q   <= {vdc, {F{1'b0}}};
    end
  end

  // Two identical bit-serial dividers, one per sector edge
  logic [PW-1:0] quo [N_CH];
  logic [N_CH-1:0] done_v;
  for (genvar g = 0; g < N_CH; g++) begin : g_div
    logic [PW-1:0] num;
    assign num = PW'(n_q[g]) * PW'(ts_q);
    svp_divider #(.PW(PW), .DW(DW)) div_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .start    (start_div),
      .dividend (num),
      .divisor  (dvs_q),
      .quotient (quo[g]),
      .done     (done_v[g])
    );
  end
  assign all_done = &done_v;

  // Triangle and dwell arithmetic on the quotients
  logic [2:0]    sub_c;
  logic [TW-1:0] t0_c, t1_c, t2_c;
  svp_dwell_calc #(.NU(NU), .DW(DW), .PW(PW), .TW(TW)) dwell_i (
    .n1  (n_q[0]),
    .n2  (n_q[1]),
    .dvs (dvs_q),
    .q1  (quo[0]),
    .q2  (quo[1]),
    .ts  (ts_q),
    .sub (sub_c),
    .t0  (t0_c),
    .t1  (t1_c),
    .t2  (t2_c)
  );

  // Control next state
  always_comb begin
    state_d = state_q;
    out_en  = 1'b0;
    case (state_q)
      ST_IDLE:  if (cap_en) state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT: begin
        if (all_done) begin
          state_d = ST_IDLE;
          out_en  = 1'b1;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
    if (out_en)       rv_d = 1'b1;
    else if (res_ack) rv_d = 1'b0;
    else              rv_d = rv_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rv_q    <= rv_d;
    end
  end

  // Result registers
  logic [2:0]    sec_o, sub_o;
  logic [TW-1:0] t0_o, t1_o, t2_o;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sec_o <= '0;
      sub_o <= '0;
      t0_o  <= '0;
      t1_o  <= '0;
      t2_o  <= '0;
    end else if (out_en) begin
      sec_o <= sec_q;
      sub_o <= sub_c;
      t0_o  <= t0_c;
      t1_o  <= t1_c;
      t2_o  <= t2_c;
    end
  end

  assign res_valid = rv_q;
  assign sector    = sec_o;
  assign subsector = sub_o;
  assign dwell0    = t0_o;
  assign dwell1    = t1_o;
  assign dwell2    = t2_o;
endmodule

// File: rtl/svp_locator_chk.sv
module svp_locator_chk #(
  parameter int TW  = 16,
  parameter int LAT = 51
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic          res_valid,
  input logic          res_ack,
  input logic [2:0]    sector,
  input logic [2:0]    subsector,
  input logic [TW-1:0] dwell0,
  input logic [TW-1:0] dwell1,
  input logic [TW-1:0] dwell2,
  input logic [TW-1:0] ts_q
);
  localparam int CW = $clog2(LAT + 2);

  logic [CW-1:0] lat_cnt;
  logic          counting;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt  <= '0;
      counting <= 1'b0;
    end else if (smp_valid && smp_ready) begin
      lat_cnt  <= '0;
      counting <= 1'b1;
    end else if (counting && !res_valid) begin
      lat_cnt  <= lat_cnt + 1'b1;
    end else if (res_valid) begin
      counting <= 1'b0;
    end
  end

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
  // R2
  busy_while_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !smp_ready);
  // R3
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (lat_cnt == CW'(LAT)));
  // R4
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ack) |=> (res_valid && $stable(sector) && $stable(subsector)
      && $stable(dwell0) && $stable(dwell1) && $stable(dwell2)));
  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ack) |=> !res_valid);
  // R5
  sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (sector >= 3'd1 && sector <= 3'd6));
  // R7
  sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (subsector >= 3'd1 && subsector <= 3'd4));
  // R10
  dwell_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (({2'b00, dwell0} + {2'b00, dwell1} + {2'b00, dwell2}) == {2'b00, ts_q}));
endmodule

bind svp_locator svp_locator_chk #(.TW(TW), .LAT(LAT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .res_valid (res_valid),
  .res_ack   (res_ack),
  .sector    (sector),
  .subsector (subsector),
  .dwell0    (dwell0),
  .dwell1    (dwell1),
  .dwell2    (dwell2),
  .ts_q      (ts_q)
);

// File: tb/svp_locator_tb_top.sv
`timescale 1ns/1ps
module svp_locator_tb_top;
  localparam int W = 16, VW = 16, TW = 16, F = 15;
  localparam int LAT = (W + F + 2) + TW + 2;
  localparam longint KQ = longint'(1.7320508075688772 * (2.0 ** F));

  logic clk = 1'b0;
  logic rst_n;
  logic smp_valid, res_ack, smp_ready, res_valid;
  logic signed [W-1:0] v_alpha, v_beta;
  logic [VW-1:0] vdc;
  logic [TW-1:0] ts;
  logic [2:0] sector, subsector;
  logic [TW-1:0] dwell0, dwell1, dwell2;

  int n_tests = 0;
  int n_fail  = 0;
  bit hit [1:6][1:4];

  always #10 clk = ~clk;

  svp_locator #(.W(W), .VW(VW), .TW(TW), .F(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .v_alpha(v_alpha), .v_beta(v_beta), .vdc(vdc), .ts(ts),
    .res_valid(res_valid), .res_ack(res_ack), .sector(sector),
    .subsector(subsector), .dwell0(dwell0), .dwell1(dwell1), .dwell2(dwell2)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint clampv(input longint v, input longint hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  // Expected values from R5..R10
  task automatic model(input longint al, input longint be, input longint vd, input longint tv,
                       output int sec, output int sub, output longint e0, output longint e1,
                       output longint e2);
    longint tx, ty, pa, pb, pc, n1, n2, d, q1, q2, r0, r2;
    tx = al * 3 * (longint'(1) << F);
    ty = be * KQ;
    pa = 2 * ty; pb = tx - ty; pc = tx + ty;
    if      (pb > 0 && pa >= 0) begin sec = 1; n1 = pb;  n2 = pa;  end
    else if (pc > 0 && pb <= 0) begin sec = 2; n1 = pc;  n2 = -pb; end
    else if (pa > 0 && pc <= 0) begin sec = 3; n1 = pa;  n2 = -pc; end
    else if (pb < 0 && pa <= 0) begin sec = 4; n1 = -pb; n2 = -pa; end
    else if (pc < 0 && pb >= 0) begin sec = 5; n1 = -pc; n2 = pb;  end
    else if (pa < 0 && pc >= 0) begin sec = 6; n1 = -pa; n2 = pc;  end
    else                        begin sec = 1; n1 = 0;   n2 = 0;   end
    d = vd << F;
    if (n1 >= d && n2 >= d) sub = (n1 >= n2) ? 3 : 4;
    else if (n1 >= d)       sub = 3;
    else if (n2 >= d)       sub = 4;
    else if (n1 + n2 < d)   sub = 1;
    else                    sub = 2;
    q1 = (n1 * tv) / d; if (q1 > 2 * tv) q1 = 2 * tv;
    q2 = (n2 * tv) / d; if (q2 > 2 * tv) q2 = 2 * tv;
    case (sub)
      2: begin r0 = tv - q2; r2 = tv - q1; end
      3: begin r0 = q1 - tv; r2 = q2;      end
      4: begin r0 = q1;      r2 = q2 - tv; end
      default: begin r0 = q1; r2 = q2; end
    endcase
    e0 = clampv(r0, tv);
    e2 = clampv(r2, tv);
    if (e0 + e2 > tv) e2 = tv - e0;
    e1 = tv - e0 - e2;
  endtask

  task automatic run_vec(input longint al, input longint be, input longint vd, input longint tv,
                         input bit poke, input int hold);
    int sec, sub, cnt, guard;
    longint e0, e1, e2;
    logic [2:0] hs, hb;
    logic [TW-1:0] h0, h1, h2;
    model(al, be, vd, tv, sec, sub, e0, e1, e2);
    guard = 0;
    while (!smp_ready && guard < 300) begin @(negedge clk); guard++; end
    v_alpha = W'(al); v_beta = W'(be); vdc = VW'(vd); ts = TW'(tv);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    check("R2 ready low after accept", smp_ready, 0);
    if (poke) begin
      smp_valid = 1'b1;
      v_alpha = W'(-al); v_beta = W'(be + 1234); vdc = VW'(vd / 2 + 1); ts = TW'(tv / 3 + 7);
    end
    cnt = 0;
    while (!res_valid && cnt < 300) begin @(negedge clk); cnt++; end
    smp_valid = 1'b0;
    check("R3 latency", cnt, LAT);
    check("R5 sector", sector, sec);
    check("R7 subsector", subsector, sub);
    check("R9 R10 dwell0", dwell0, e0);
    check("R10 dwell1", dwell1, e1);
    check("R9 R10 dwell2", dwell2, e2);
    if (sector >= 1 && sector <= 6 && subsector >= 1 && subsector <= 4)
      hit[sector][subsector] = 1'b1;
    hs = sector; hb = subsector; h0 = dwell0; h1 = dwell1; h2 = dwell2;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R4 hold valid", res_valid, 1);
      check("R4 hold data", {hs, hb, h0, h1, h2} == {sector, subsector, dwell0, dwell1, dwell2}, 1);
      check("R2 ready low while result", smp_ready, 0);
    end
    res_ack = 1'b1;
    @(negedge clk);
    res_ack = 1'b0;
    check("R4 ack clears valid", res_valid, 0);
    check("R4 ready after ack", smp_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; res_ack = 1'b0;
    v_alpha = '0; v_beta = '0; vdc = '0; ts = '0;
    repeat (3) @(posedge clk);
    check("R1 valid in reset", res_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid after reset", res_valid, 0);
    check("R1 ready after reset", smp_ready, 1);
    check("R1 outputs zero", {sector, subsector, dwell0, dwell1, dwell2}, 0);

    // R11 zero reference
    run_vec(0, 0, 20000, 1000, 0, 0);
    check("R11 origin sector", sector, 1);
    // R2 busy pokes ignored, R4 hold without ack
    run_vec(9000, 3000, 20000, 1000, 1, 6);
    run_vec(-4000, -7000, 30000, 500, 1, 3);
    // R6 R8 grid sweep over all sectors, two settings
    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int ia = -6; ia <= 6; ia++) begin
        for (int ib = -6; ib <= 6; ib++) begin
          if (cfg == 0) run_vec(ia * 2500, ib * 2500, 20000, 1000, 0, 0);
          else          run_vec(ia * 2500, ib * 2500, 40000, 777, 0, 0);
        end
      end
    end
    // R7 every triangle of every sector reached
    for (int s = 1; s <= 6; s++)
      for (int b = 1; b <= 4; b++)
        check($sformatf("R7 coverage sector %0d sub %0d", s, b), hit[s][b], 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule